// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every beat of a memory burst. A start strobe captures a start column together with the burst settings: a length code, a wrap order and a write flag. From the next clock on, the block emits one column per accepted beat and flags the final beat. Fixed-length bursts of 2, 4 or 8 beats stay inside the aligned block that holds the start column. In that block the low address bits step either sequentially with wrap-around or in interleaved order. A full-page burst walks the whole 512-column row and wraps at the row end. It runs until a terminate or a new start arrives.

A new start may arrive on any clock, including in the middle of a burst, and it restarts the sequence at once. A mode bit can force every write burst down to a single beat; read bursts still use the programmed length. The outgoing beat stream is valid/ready. A beat is consumed on a clock where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, `col` and `last` hold. Start and terminate act whatever the state of `out_ready`.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `out_valid` and `last` are low until the first start strobe.
- R2: On the clock after `start` is sampled high, `out_valid` is high and `col` equals the sampled `start_col`.
- R3: With `wrap_il`=0 and fixed length N, beat k keeps every column bit above the low log2(N) bits equal to the start column, and the low bits equal (start offset + k) mod N.
- R4: With `wrap_il`=1 and fixed length N, beat k keeps the upper bits equal to the start column, and the low bits equal the start offset XOR k.
- R5: The length codes are 0=1 beat, 1=2, 2=4, 3=8 and 7=full page; codes 4 to 6 give one beat. `last` is high exactly on beat N-1, and `out_valid` is low after that beat is consumed.
- R6: In full-page mode, beat k is (start + k) mod 512 whatever the value of `wrap_il`, and `last` is never high.
- R7: When `terminate` is sampled high without `start`, `out_valid` is low on the next clock.
- R8: When `wr_single_mode` is 1 and `start_is_write` is 1 at the start, the burst has one beat with `last` high, whatever the length code. Read starts in that mode keep the programmed length.
- R9: While `out_valid` is high and `out_ready` is low, with no start and no terminate, `col`, `last` and `out_valid` hold.
- R10: A start during an active burst takes priority over terminate and over the beat in progress. The next beat is the new start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst at `start_col` |
| start_col | input | 9 | Start column, sampled with `start` |
| len_code | input | 3 | Burst length code, sampled with `start` |
| wrap_il | input | 1 | 1 = interleaved order, 0 = sequential, sampled with `start` |
| wr_single_mode | input | 1 | Write bursts limited to a single beat |
| start_is_write | input | 1 | The burst being started is a write |
| terminate | input | 1 | End the current burst |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A beat column is presented |
| col | output | 9 | Column address of the current beat |
| last | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
On every cycle, the assertions check three things: that a start loads its column on the next clock, that a terminate empties the stream, and that a stalled beat holds its column. They also check that `last` only appears with a valid beat and never follows a full-page start, and that the stream stops after a consumed last beat. The bench alone can show the actual beat orders. It compares sequential and interleaved wrapping for every length and every start offset against orders it computes itself. It also covers the row-end wrap of full-page bursts, the single-beat write mode and the restart of a burst part way through.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_FULL_PAGE = 3'd7;

  typedef struct packed {
    logic [3:0] mask;
    logic       full;
    logic       il;
  } burst_cfg_t;

  function automatic burst_cfg_t decode_cfg(
    input logic [LEN_CODE_W-1:0] code,
    input logic                  il,
    input logic                  force_single
  );
    burst_cfg_t c;
    c.il   = il;
    c.full = 1'b0;
    c.mask = 4'd0;
    if (!force_single) begin
      unique case (code)
        3'd1: c.mask = 4'd1;
        3'd2: c.mask = 4'd3;
        3'd3: c.mask = 4'd7;
        LEN_FULL_PAGE: c.full = 1'b1;
        default: c.mask = 4'd0;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/bcs_cfg_latch.sv
module bcs_cfg_latch
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  wrap_il,
  input  logic                  wr_single_mode,
  input  logic                  start_is_write,
  output burst_cfg_t            cfg,
  output logic [COL_W-1:0]      base_col
);
  burst_cfg_t cfg_next;

  always_comb begin
    cfg_next = decode_cfg(len_code, wrap_il, wr_single_mode && start_is_write);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      base_col <= '0;
    end else if (start) begin
      cfg      <= cfg_next;
      base_col <= start_col;
    end
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             terminate,
  input  logic             out_ready,
  input  burst_cfg_t       cfg,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_idx,
  output logic             beat_last
);
  logic [COL_W-1:0] mask_ext;

  always_comb begin
    mask_ext  = COL_W'(cfg.mask);
    beat_last = beat_valid && !cfg.full && (beat_idx == mask_ext);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_valid <= 1'b0;
      beat_idx   <= '0;
    end else if (start) begin
      beat_valid <= 1'b1;
      beat_idx   <= '0;
    end else if (terminate) begin
      beat_valid <= 1'b0;
    end else if (beat_valid && out_ready) begin
      if (beat_last) begin
        beat_valid <= 1'b0;
      end else begin
        beat_idx <= beat_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  burst_cfg_t       cfg,
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_idx,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] span_mask;
  logic [COL_W-1:0] low_part;

  always_comb begin
    span_mask = cfg.full ? {COL_W{1'b1}} : COL_W'(cfg.mask);
    if (cfg.il && !cfg.full) begin
      low_part = base_col ^ beat_idx;
    end else begin
      low_part = base_col + beat_idx;
    end
    col = (base_col & ~span_mask) | (low_part & span_mask);
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  wrap_il,
  input  logic                  wr_single_mode,
  input  logic                  start_is_write,
  input  logic                  terminate,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [COL_W-1:0]      col,
  output logic                  last
);
  burst_cfg_t       cfg;
  logic [COL_W-1:0] base_col;
  logic [COL_W-1:0] beat_idx;

  bcs_cfg_latch #(.COL_W(COL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .wrap_il(wrap_il), .wr_single_mode(wr_single_mode),
    .start_is_write(start_is_write), .cfg(cfg), .base_col(base_col)
  );

  bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .terminate(terminate),
    .out_ready(out_ready), .cfg(cfg), .beat_valid(out_valid),
    .beat_idx(beat_idx), .beat_last(last)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .cfg(cfg), .base_col(base_col), .beat_idx(beat_idx), .col(col)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [COL_W-1:0]      start_col,
  input logic [LEN_CODE_W-1:0] len_code,
  input logic                  wr_single_mode,
  input logic                  start_is_write,
  input logic                  terminate,
  input logic                  out_ready,
  input logic                  out_valid,
  input logic [COL_W-1:0]      col,
  input logic                  last
);
  // R2
  start_loads_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid && (col == $past(start_col)));

  // R7
  terminate_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    terminate && !start |=> !out_valid);

  // R9
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start && !terminate |=> out_valid && $stable(col) && $stable(last));

  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && last && out_ready && !start && !terminate |=> !out_valid);

  // R5
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> out_valid);

  // R6
  full_page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && (len_code == LEN_FULL_PAGE) && !(wr_single_mode && start_is_write) |=> !last);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_chk (.*);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 9;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic wrap_il = 1'b0;
  logic wr_single_mode = 1'b0;
  logic start_is_write = 1'b0;
  logic terminate = 1'b0;
  logic out_ready = 1'b1;
  logic out_valid;
  logic [COL_W-1:0] col;
  logic last;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [COL_W-1:0] sc, input logic [2:0] lc, input logic il, input logic wr);
    start_col = sc; len_code = lc; wrap_il = il; start_is_write = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] sc, input int n, input logic il, input int k);
    logic [COL_W-1:0] m = COL_W'(n - 1);
    logic [COL_W-1:0] lo = il ? (sc ^ COL_W'(k)) : (sc + COL_W'(k));
    return (sc & ~m) | (lo & m);
  endfunction

  task automatic run_fixed(input logic [COL_W-1:0] sc, input logic [2:0] lc, input logic il, input int n, input string req);
    kick(sc, lc, il, 1'b0);
    for (int k = 0; k < n; k++) begin
      chk({req, " valid"}, 32'(out_valid), 32'd1);
      chk({req, " col"}, 32'(col), 32'(exp_col(sc, n, il, k)));
      chk("R5 last", 32'(last), 32'(k == n - 1));
      @(negedge clk);
    end
    chk("R5 end", 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(out_valid), 32'd0);
    chk("R1 last", 32'(last), 32'd0);
  endtask

  task automatic t_orders();
    for (int lc = 0; lc < 4; lc++) begin
      for (int il = 0; il < 2; il++) begin
        for (int off = 0; off < 8; off++) begin
          run_fixed(COL_W'(9'h1A8 | off), 3'(lc), 1'(il), 1 << lc, il ? "R4" : "R3");
        end
      end
    end
    run_fixed(9'h0C5, 3'd5, 1'b0, 1, "R5 code5");
  endtask

  task automatic t_full_page();
    kick(9'd508, 3'd7, 1'b1, 1'b0);
    for (int k = 0; k < 10; k++) begin
      chk("R6 col", 32'(col), 32'((508 + k) % 512));
      chk("R6 last", 32'(last), 32'd0);
      @(negedge clk);
    end
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    chk("R7 terminated", 32'(out_valid), 32'd0);
  endtask

  task automatic t_single_write();
    wr_single_mode = 1'b1;
    kick(9'h033, 3'd3, 1'b0, 1'b1);
    chk("R8 col", 32'(col), 32'h033);
    chk("R8 last", 32'(last), 32'd1);
    @(negedge clk);
    chk("R8 end", 32'(out_valid), 32'd0);
    kick(9'h033, 3'd3, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 read keeps length", 32'(col), 32'h034);
    chk("R8 read last", 32'(last), 32'd0);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    wr_single_mode = 1'b0;
  endtask

  task automatic t_stall();
    kick(9'h040, 3'd2, 1'b0, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 hold valid", 32'(out_valid), 32'd1);
      chk("R9 hold col", 32'(col), 32'h041);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 resume", 32'(col), 32'h042);
    @(negedge clk);
    @(negedge clk);
    chk("R9 end", 32'(out_valid), 32'd0);
  endtask

  task automatic t_restart();
    kick(9'h010, 3'd3, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 mid", 32'(col), 32'h012);
    terminate = 1'b1;
    kick(9'h155, 3'd2, 1'b1, 1'b0);
    terminate = 1'b0;
    chk("R2 restart col", 32'(col), 32'h155);
    chk("R10 restart valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    chk("R10 new order", 32'(col), 32'h154);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    chk("R7 end", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_orders();
    t_full_page();
    t_single_write();
    t_stall();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule